// File: doc/BRIEF.md
# PHY Delay Register Indirect Access Port

This block lets a host reach a small bank of PHY delay settings through one 32-bit host register. The host never addresses a delay slot directly. It places a slot index and a data byte in fields of the access register, then raises a strobe bit in a later write. A rising write strobe stores the data byte into the indexed slot. A rising read strobe copies the indexed slot into a result field of the same register and raises an acknowledge bit. Software clears both strobes to finish the handshake, and that also clears the acknowledge.

The bank has nine 8-bit slots, one for each bus timing mode. In index order these are SD high speed, SD default speed, UHS SDR12, UHS SDR25, UHS SDR50, UHS DDR50, eMMC legacy, eMMC SDR and eMMC DDR. A downstream delay line selects one slot with a mode input and receives that slot's value on a plain output.

Top module: `phy_access_port`

## Requirements
- R1: After reset the access register reads 0. The slots hold 4, 4, 0, 0, 0, 0, 9, 2, 3 for indices 0 through 8.
- R2: The access register sits at byte offset 0x10. Bits [7:0] and [15:8] read back as last written. Bits [23:16] and [31:27] ignore host writes. Every other offset reads 0 and ignores writes.
- R3: In a host write where bit 24 goes from 0 to 1, bits [15:8] of that write are stored into the slot indexed by bits [7:0] of the same write.
- R4: Leaving bit 24 at 1 in later host writes stores nothing, even when the data field changes. One rising edge gives exactly one store.
- R5: In a host write where bit 25 goes from 0 to 1, the indexed slot is copied into bits [23:16] and bit 26 (acknowledge) is set. The copy takes the slot's value from before any store in the same write.
- R6: Bits 24 and 25 read back the strobe levels last written. The acknowledge stays set while either strobe is 1. It clears in a host write that leaves both strobes at 0.
- R7: A store to an index of 9 or more changes no slot. A read strobe at such an index returns 0 in bits [23:16] and still sets the acknowledge.
- R8: The delay output equals the slot indexed by the 4-bit mode input. A mode value of 9 or more gives 0.
- R9: Bits [23:16] keep the last read result through host writes that carry no rising read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Host write enable, one cycle per write |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr, combinational |
| mode_sel | input | 4 | Timing mode index that selects a slot for the delay line |
| delay_out | output | 8 | Delay value of the selected slot |

## Verification
The hardest case to reach is a host write that changes the data field while a strobe is already held high. The single-edge rule must suppress a second store there, and the acknowledge must survive it. A plain three-step sequence never produces that write. The directed part of the bench builds it on purpose and also raises both strobes in one write. The random part then sends arbitrary 32-bit words to the access register and to neighbouring offsets. This produces held strobes, simultaneous edges and out-of-range indices in many orders. Each word is checked against a bench model of the register and of all nine slots.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;

   localparam int unsigned HOST_W    = 32;
   localparam int unsigned FIELD_W   = 8;
   localparam int unsigned IDX_LSB   = 0;
   localparam int unsigned WDAT_LSB  = 8;
   localparam int unsigned RDAT_LSB  = 16;
   localparam int unsigned WSTB_BIT  = 24;
   localparam int unsigned RSTB_BIT  = 25;
   localparam int unsigned ACK_BIT   = 26;
   localparam int unsigned NUM_STB   = 2;

   typedef enum int unsigned {
      TM_SD_HIGHSPD = 0,
      TM_SD_BASE    = 1,
      TM_UHS_12     = 2,
      TM_UHS_25     = 3,
      TM_UHS_50     = 4,
      TM_UHS_DDR    = 5,
      TM_EMMC_BASE  = 6,
      TM_EMMC_SDR   = 7,
      TM_EMMC_DDR   = 8
   } timing_slot_e;

   typedef struct packed {
      logic [FIELD_W-1:0] idx;
      logic [FIELD_W-1:0] wdat;
   } phy_req_t;

   function automatic logic [FIELD_W-1:0] slot_init(input int unsigned idx);
      logic [FIELD_W-1:0] v;
      case (idx)
         TM_SD_HIGHSPD: v = FIELD_W'(4);
         TM_SD_BASE:    v = FIELD_W'(4);
         TM_EMMC_BASE:  v = FIELD_W'(9);
         TM_EMMC_SDR:   v = FIELD_W'(2);
         TM_EMMC_DDR:   v = FIELD_W'(3);
         default:       v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/phy_acc_edge.sv
module phy_acc_edge #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             sample_en,
   input  logic [WIDTH-1:0] level_old,
   input  logic [WIDTH-1:0] level_new,
   output logic [WIDTH-1:0] rise
);

   if (WIDTH < 1) begin : g_bad_width
      $error("phy_acc_edge: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise[b] = sample_en & level_new[b] & ~level_old[b];
   end

endmodule

// File: rtl/phy_delay_file.sv
module phy_delay_file
   import phy_acc_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 9,
   parameter int unsigned MODE_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  phy_req_t           wreq,
   input  logic [FIELD_W-1:0] raddr,
   output logic [FIELD_W-1:0] rdata,
   input  logic [MODE_W-1:0]  mode_sel,
   output logic [FIELD_W-1:0] delay_out
);

   localparam logic [FIELD_W:0] SLOT_LIMIT = (FIELD_W+1)'(NUM_SLOTS);

   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << FIELD_W)) begin : g_bad_slots
      $error("phy_delay_file: NUM_SLOTS must lie in 1..2**FIELD_W");
   end
   if (NUM_SLOTS > (1 << MODE_W)) begin : g_bad_mode
      $error("phy_delay_file: MODE_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0][FIELD_W-1:0] slot_q;
   logic waddr_ok;

   assign waddr_ok = ({1'b0, wreq.idx} < SLOT_LIMIT);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= slot_init(i);
         else if (we && wreq.idx == FIELD_W'(i))
            slot_q[i] <= wreq.wdat;
      end

      assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wreq.idx == FIELD_W'(i)) |=> slot_q[i] == $past(wreq.wdat));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (raddr == FIELD_W'(i)) rdata = slot_q[i];
   end

   always_comb begin
      delay_out = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (mode_sel == MODE_W'(i)) delay_out = slot_q[i];
   end

   assert_bad_index_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !waddr_ok) |=> $stable(slot_q));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(slot_q));

endmodule

// File: rtl/phy_acc_host_reg.sv
module phy_acc_host_reg
   import phy_acc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit,
   input  logic [HOST_W-1:0]  wr_word,
   input  logic [FIELD_W-1:0] rd_value,
   output logic [HOST_W-1:0]  reg_value,
   output logic               phy_we,
   output phy_req_t           phy_req,
   output logic [FIELD_W-1:0] phy_raddr
);

   logic [FIELD_W-1:0] idx_q, wdat_q, rdat_q;
   logic               wstb_q, rstb_q, ack_q;
   logic [NUM_STB-1:0] stb_new, stb_old, stb_rise;
   logic               rd_rise;

   assign stb_new = {wr_word[RSTB_BIT], wr_word[WSTB_BIT]};
   assign stb_old = {rstb_q, wstb_q};

   phy_acc_edge #(.WIDTH(NUM_STB)) u_edge (
      .sample_en (wr_hit),
      .level_old (stb_old),
      .level_new (stb_new),
      .rise      (stb_rise)
   );

   assign rd_rise      = stb_rise[1];
   assign phy_we       = stb_rise[0];
   assign phy_req.idx  = wr_word[IDX_LSB +: FIELD_W];
   assign phy_req.wdat = wr_word[WDAT_LSB +: FIELD_W];
   assign phy_raddr    = wr_word[IDX_LSB +: FIELD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
         wstb_q <= 1'b0;
         rstb_q <= 1'b0;
         ack_q  <= 1'b0;
      end else if (wr_hit) begin
         idx_q  <= wr_word[IDX_LSB +: FIELD_W];
         wdat_q <= wr_word[WDAT_LSB +: FIELD_W];
         wstb_q <= wr_word[WSTB_BIT];
         rstb_q <= wr_word[RSTB_BIT];
         if (rd_rise) begin
            rdat_q <= rd_value;
            ack_q  <= 1'b1;
         end else if (stb_new == '0) begin
            ack_q  <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_value                          = '0;
      reg_value[IDX_LSB +: FIELD_W]      = idx_q;
      reg_value[WDAT_LSB +: FIELD_W]     = wdat_q;
      reg_value[RDAT_LSB +: FIELD_W]     = rdat_q;
      reg_value[WSTB_BIT]                = wstb_q;
      reg_value[RSTB_BIT]                = rstb_q;
      reg_value[ACK_BIT]                 = ack_q;
   end

   assert_ack_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(rd_rise));

   assert_ack_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> rdat_q == $past(rd_value));

   assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wstb_q && !rstb_q) |-> !ack_q);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_rise) |-> $stable(rdat_q));

endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
   import phy_acc_pkg::*;
#(
   parameter int unsigned BUS_ADDR_W = 12,
   parameter int unsigned ACC_OFFSET = 16,
   parameter int unsigned NUM_SLOTS  = 9,
   parameter int unsigned MODE_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wen,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic [HOST_W-1:0]     bus_wdata,
   output logic [HOST_W-1:0]     bus_rdata,
   input  logic [MODE_W-1:0]     mode_sel,
   output logic [FIELD_W-1:0]    delay_out
);

   localparam logic [BUS_ADDR_W-1:0] ACC_ADDR = BUS_ADDR_W'(ACC_OFFSET);

   if (ACC_OFFSET % 4 != 0) begin : g_bad_align
      $error("phy_access_port: ACC_OFFSET must be word aligned");
   end
   if (ACC_OFFSET >= (1 << BUS_ADDR_W)) begin : g_bad_offset
      $error("phy_access_port: ACC_OFFSET outside the bus address range");
   end

   logic               acc_sel, acc_hit, phy_we;
   logic [HOST_W-1:0]  acc_value;
   logic [FIELD_W-1:0] phy_raddr, phy_rdata;
   phy_req_t           phy_req;
   logic               unused_bits;

   assign acc_sel     = (bus_addr == ACC_ADDR);
   assign acc_hit     = bus_wen & acc_sel;
   assign bus_rdata   = acc_sel ? acc_value : '0;
   assign unused_bits = ^{bus_wdata[HOST_W-1:ACK_BIT], bus_wdata[RDAT_LSB +: FIELD_W]};

   phy_acc_host_reg u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (acc_hit),
      .wr_word   (bus_wdata),
      .rd_value  (phy_rdata),
      .reg_value (acc_value),
      .phy_we    (phy_we),
      .phy_req   (phy_req),
      .phy_raddr (phy_raddr)
   );

   phy_delay_file #(.NUM_SLOTS(NUM_SLOTS), .MODE_W(MODE_W)) u_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (phy_we),
      .wreq      (phy_req),
      .raddr     (phy_raddr),
      .rdata     (phy_rdata),
      .mode_sel  (mode_sel),
      .delay_out (delay_out)
   );

   assert_single_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phy_we |=> !phy_we);

   assert_store_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phy_we |-> (bus_wen && bus_addr == ACC_ADDR));

endmodule

// File: tb/phy_access_port_test.sv
module phy_access_port_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] ACC = 12'h010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  mode_sel = '0;
   logic [7:0]  delay_out;

   int n_checks = 0;
   int n_fail = 0;

   logic [7:0] m_slot [0:8];
   logic [7:0] m_idx, m_wdat, m_rdat;
   logic       m_wstb, m_rstb, m_ack;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_access_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mode_sel(mode_sel), .delay_out(delay_out)
   );

   function automatic logic [7:0] init_val(int i);
      case (i)
         0, 1: return 8'd4;
         6: return 8'd9;
         7: return 8'd2;
         8: return 8'd3;
         default: return 8'd0;
      endcase
   endfunction

   function automatic logic [31:0] exp_reg();
      return {5'b0, m_ack, m_rstb, m_wstb, m_rdat, m_wdat, m_idx};
   endfunction

   function automatic logic [7:0] exp_dly(logic [3:0] m);
      return (m < 9) ? m_slot[m] : 8'd0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 9; i++) m_slot[i] = init_val(i);
      m_idx = 0; m_wdat = 0; m_rdat = 0; m_wstb = 0; m_rstb = 0; m_ack = 0;
   endtask

   task automatic model_write(logic [11:0] a, logic [31:0] d);
      logic wr_r, rd_r;
      if (a != ACC) return;
      wr_r = d[24] & ~m_wstb;
      rd_r = d[25] & ~m_rstb;
      if (rd_r) begin
         m_rdat = (d[7:0] < 9) ? m_slot[d[7:0]] : 8'd0;
         m_ack = 1'b1;
      end else if (!d[24] && !d[25]) begin
         m_ack = 1'b0;
      end
      if (wr_r && d[7:0] < 9) m_slot[d[7:0]] = d[15:8];
      m_idx = d[7:0]; m_wdat = d[15:8]; m_wstb = d[24]; m_rstb = d[25];
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wen = 1'b0;
      model_write(a, d);
   endtask

   task automatic check_reg(string req);
      bus_addr = ACC; #1;
      check(req, bus_rdata, exp_reg());
   endtask

   task automatic check_dly(string req, logic [3:0] m);
      mode_sel = m; #1;
      check(req, {24'd0, delay_out}, {24'd0, exp_dly(m)});
   endtask

   task automatic phy_store(logic [7:0] a, logic [7:0] d);
      host_wr(ACC, {16'd0, d, a});
      host_wr(ACC, {7'd0, 1'b1, 8'd0, d, a});
      host_wr(ACC, {16'd0, d, a});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_reg("R1");
      for (int m = 0; m < 9; m++) check_dly("R1", 4'(m));

      // R8: out-of-range mode gives zero
      check_dly("R8", 4'd9);
      check_dly("R8", 4'd15);

      // R3: three-step store
      phy_store(8'd3, 8'hA5);
      check_dly("R3", 4'd3);
      check_reg("R3");

      // R4: strobe held high with new data does not store again
      host_wr(ACC, {7'd0, 1'b1, 8'd0, 8'h11, 8'd2});
      host_wr(ACC, {7'd0, 1'b1, 8'd0, 8'h22, 8'd2});
      check_dly("R4", 4'd2);
      check(" R4 slot", {24'd0, delay_out}, 32'h11);
      host_wr(ACC, 32'd0);

      // R5: read returns slot and sets ack
      host_wr(ACC, {7'd0, 2'b10, 8'd0, 8'h00, 8'd6});
      check_reg("R5");
      check("R5 ack", {31'd0, bus_rdata[26]}, 32'd1);
      check("R5 data", {24'd0, bus_rdata[23:16]}, 32'd9);

      // R6: ack held while a strobe is high, cleared when both low
      host_wr(ACC, {7'd0, 2'b01, 8'd0, 8'h00, 8'd6});
      check("R6 hold", {31'd0, bus_rdata[26]}, 32'd1);
      host_wr(ACC, {16'd0, 8'h00, 8'd6});
      check("R6 clear", {31'd0, bus_rdata[26]}, 32'd0);
      // R9: result field survives writes without a read edge
      check("R9", {24'd0, bus_rdata[23:16]}, 32'd9);

      // R5: both strobes rise together, read sees old value
      host_wr(ACC, {7'd0, 2'b11, 8'd0, 8'h77, 8'd7});
      check("R5 old", {24'd0, bus_rdata[23:16]}, 32'd2);
      check_dly("R3", 4'd7);
      host_wr(ACC, 32'd0);

      // R7: out-of-range store ignored, out-of-range read gives zero
      phy_store(8'd9, 8'hEE);
      phy_store(8'hFF, 8'hEE);
      for (int m = 0; m < 9; m++) check_dly("R7", 4'(m));
      host_wr(ACC, {7'd0, 2'b10, 8'd0, 8'h00, 8'd12});
      check("R7 read", {24'd0, bus_rdata[23:16]}, 32'd0);
      check("R7 ack", {31'd0, bus_rdata[26]}, 32'd1);
      host_wr(ACC, 32'd0);

      // R2: other offsets ignored, ignored bits in the access word
      host_wr(12'h014, 32'h01FF_FF01);
      host_wr(12'h000, 32'h0100_5501);
      bus_addr = 12'h014; #1;
      check("R2 other", bus_rdata, 32'd0);
      check_reg("R2");
      check_dly("R2", 4'd1);
      host_wr(ACC, 32'hF8FF_3402);
      check_reg("R2 ignored bits");

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [31:0] d;
         logic [11:0] a;
         int sel;
         sel = $urandom_range(0, 9);
         a = (sel < 7) ? ACC : ((sel == 7) ? 12'h014 : ((sel == 8) ? 12'h00C : 12'h000));
         d = $urandom;
         d[7:0] = 8'($urandom_range(0, 11));
         host_wr(a, d);
         check_reg("R2 R3 R5 R6 random");
         check_dly("R8 random", 4'($urandom_range(0, 15)));
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule